// File: doc/BRIEF.md
# Serial Control Word Receiver with Output-Mode Override

This block takes 12-bit control words from a three-wire link (an active-low frame enable, a serial clock and a data line) and turns them into two held settings: an 8-bit code for a downstream control DAC and a programmed output mode that can ground the video outputs. All three serial wires are sampled into the system clock domain through synchronizer stages. Edges are detected there, so the link may run at any rate well below the system clock.

A frame opens when the enable falls. Data bits are shifted in, most significant first, on each rising serial clock while the enable stays low. The frame is acted on only when the enable rises again, and only if at least three serial clocks were seen. The top word bit picks the programmed mode. The next bit down decides whether the low byte is copied into the DAC code register, and a one-cycle load strobe marks that copy. Two hardware pins sit above the serial setting. With the select pin high, the serial mode bit rules. With it low, the switch pin decides, and a low on the switch pin grounds the outputs at once with no clock involved.

Top module: `ctl_word_rx`

## Requirements
- R1: After reset the DAC code is 0, the programmed mode is normal (grounded output 0 while mode_sel is 1), and dac_load is 0.
- R2: Word bit 11 arrives first and bit 0 last. Bits 7..0 form the DAC code with bit 7 as its MSB. Bits 9 and 8 have no effect.
- R3: In an accepted frame, a 1 in word bit 10 copies bits 7..0 into dac_code and raises dac_load for exactly one clock. A 0 in bit 10 leaves dac_code unchanged and gives no pulse.
- R4: An accepted frame stores word bit 11 as the programmed mode: 1 = grounded, 0 = normal. With mode_sel = 1, gnd_mode shows the programmed mode.
- R5: A frame with fewer than three rising serial clocks while the enable is low changes neither dac_code nor the programmed mode, and gives no pulse.
- R6: A frame with 3 to 11 serial clocks acts on the last 12 bits held in the shift register, which carry over from earlier frames, including rejected ones.
- R7: With mode_sel = 0, gnd_mode is the inverse of mode_sw. A low mode_sw grounds the output combinationally, whatever mode was programmed.
- R8: The programmed mode is kept and still updated by accepted frames while mode_sel = 0. It shows again once mode_sel returns to 1.
- R9: dac_code, dac_load and the programmed mode change only after the enable rises. Bits shifted in while the enable stays low have no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Frame enable, active low |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| mode_sel | input | 1 | 1: serial mode bit rules; 0: mode_sw rules |
| mode_sw | input | 1 | With mode_sel = 0: 1 normal, 0 grounded |
| dac_code | output | 8 | Held control DAC code |
| dac_load | output | 1 | One-clock strobe when dac_code is loaded |
| gnd_mode | output | 1 | 1 = video outputs grounded |

## Verification
A slip in the bit counter or the shift register shows up as a wrong byte on dac_code, or as a pulse that is missing or extra. Either appears within three clocks of the enable rising. A stuck programmed-mode register appears on gnd_mode only while mode_sel is high, so the mode is checked both before and after each override window. A fault in the override path shows on gnd_mode at once, before any clock edge. Short frames are checked by how they change the carried-over shift-register contents that a later frame acts on.

// File: rtl/ctl_word_rx.sv
module ctl_word_rx #(
  parameter int WORD_W      = 12,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CLKS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              mode_sel,
  input  logic              mode_sw,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load,
  output logic              gnd_mode
);
  localparam int MODE_BIT = WORD_W - 1;
  localparam int LOAD_BIT = WORD_W - 2;
  localparam int CNT_W    = $clog2(MIN_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CLKS);

  logic [SYNC_STAGES:0] en_q, ck_q, dt_q;
  logic [WORD_W-1:0]    shreg;
  logic [CNT_W-1:0]     clk_cnt;
  logic                 prog_gnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
      ck_q <= '0;
      dt_q <= '0;
    end else begin
      en_q <= {en_q[SYNC_STAGES-1:0], ser_en_n};
      ck_q <= {ck_q[SYNC_STAGES-1:0], ser_clk};
      dt_q <= {dt_q[SYNC_STAGES-1:0], ser_dat};
    end
  end

  wire en_low    = !en_q[SYNC_STAGES-1];
  wire en_fall   = en_low && en_q[SYNC_STAGES];
  wire en_rise   = !en_low && !en_q[SYNC_STAGES];
  wire bit_take  = en_low && ck_q[SYNC_STAGES-1] && !ck_q[SYNC_STAGES];
  wire frame_ok  = (clk_cnt == CNT_MAX);
  wire frame_end = en_rise && frame_ok;
  wire dat_bit   = dt_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      clk_cnt <= '0;
    end else begin
      if (bit_take)
        shreg <= {shreg[WORD_W-2:0], dat_bit};
      if (en_fall)
        clk_cnt <= '0;
      else if (bit_take && !frame_ok)
        clk_cnt <= clk_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= '0;
      dac_load <= 1'b0;
      prog_gnd <= 1'b0;
    end else begin
      dac_load <= 1'b0;
      if (frame_end) begin
        prog_gnd <= shreg[MODE_BIT];
        if (shreg[LOAD_BIT]) begin
          dac_code <= shreg[CODE_W-1:0];
          dac_load <= 1'b1;
        end
      end
    end
  end

  assign gnd_mode = mode_sel ? prog_gnd : !mode_sw;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> !dac_load); // R3
  AST_CODE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> dac_load); // R3
  AST_PULSE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> $past(en_rise)); // R9
  AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && clk_cnt < CNT_MAX) |=> (!dac_load && $stable(prog_gnd))); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(prog_gnd)); // R9
endmodule

// File: tb/tb_ctl_word_rx.sv
module tb_ctl_word_rx;
  logic clk = 0, rst_n = 0;
  logic ser_en_n = 1, ser_clk = 0, ser_dat = 0, mode_sel = 1, mode_sw = 1;
  logic [7:0] dac_code;
  logic dac_load, gnd_mode;
  int checks = 0, errors = 0;
  logic [11:0] sr_model = '0;
  logic [7:0]  code_model = '0;
  logic        mode_model = 0;
  logic [7:0]  expq[$];

  ctl_word_rx dut (.clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .mode_sel(mode_sel), .mode_sw(mode_sw),
    .dac_code(dac_code), .dac_load(dac_load), .gnd_mode(gnd_mode));

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_frame();
    ser_en_n = 0; tick(4);
  endtask

  task automatic shift(input logic [11:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i]; ser_clk = 0; tick(4);
      ser_clk = 1; tick(4);
      sr_model = {sr_model[10:0], w[i]};
    end
    ser_clk = 0; tick(4);
  endtask

  task automatic close_frame(input int n);
    if (n >= 3) begin
      mode_model = sr_model[11];
      if (sr_model[10]) begin
        code_model = sr_model[7:0];
        expq.push_back(sr_model[7:0]);
      end
    end
    ser_en_n = 1; tick(8);
  endtask

  task automatic send(input logic [11:0] w, input int n);
    open_frame(); shift(w, n); close_frame(n);
  endtask

  always @(negedge clk) begin
    if (rst_n && dac_load) begin
      if (expq.size() == 0) check("R3 unexpected pulse", 1, 0);
      else check("R2 R3 loaded code", dac_code, expq.pop_front());
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    check("R1 code", dac_code, 0);
    check("R1 mode", gnd_mode, 0);
    check("R1 pulse", dac_load, 0);
    rst_n = 1; tick(3);

    send(12'h4A5, 12);
    check("R2 code A5", dac_code, 8'hA5);
    check("R4 normal", gnd_mode, 0);
    send(12'hC3C, 12);
    check("R4 grounded", gnd_mode, 1);
    send(12'h3FF, 12);
    check("R3 no load when bit10=0", dac_code, 8'h3C);
    check("R4 back to normal", gnd_mode, 0);
    send(12'hFFF, 12);
    check("R2 all ones", dac_code, 8'hFF);
    send(12'h700, 12);
    check("R2 bits 9 8 ignored", dac_code, 8'h00);

    open_frame(); shift(12'hC55, 12); tick(40);
    check("R9 code held while enable low", dac_code, 8'h00);
    check("R9 mode held while enable low", gnd_mode, 0);
    close_frame(12);
    check("R9 applied on rise", dac_code, 8'h55);
    check("R9 mode applied on rise", gnd_mode, 1);

    send(12'h001, 2);
    check("R5 short frame code", dac_code, 8'h55);
    check("R5 short frame mode", gnd_mode, 1);
    send(12'h004, 4);
    check("R6 carried shift contents code", dac_code, code_model);
    check("R6 carried shift contents mode", gnd_mode, mode_model);

    send(12'h800, 12);
    check("R4 grounded again", gnd_mode, 1);
    mode_sel = 0; mode_sw = 1; #1;
    check("R7 switch high normal", gnd_mode, 0);
    mode_sw = 0; #1;
    check("R7 switch low async ground", gnd_mode, 1);
    tick(1);
    send(12'h000, 12);
    check("R7 override holds over frame", gnd_mode, 1);
    mode_sel = 1; #1;
    check("R8 programmed normal shows", gnd_mode, 0);
    mode_sel = 0; mode_sw = 1; tick(1);
    send(12'h800, 12);
    check("R7 switch rules", gnd_mode, 0);
    mode_sel = 1; #1;
    check("R8 programmed ground shows", gnd_mode, 1);
    tick(4);
    check("R3 all pulses seen", expq.size(), 0);
    finish_run();
  end
endmodule